// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs one read or one write transfer at a time on a bus where the low address bits and the data share the same lines. A client presents a request: the address, the direction, memory or port space, and the data to write. The sequencer then steps through a fixed four-phase transfer, T1 to T4. In the first phase it puts the address on the shared lines and raises an address strobe. In the middle phases it drives the data or floats the lines, and it pulses the read or write strobe together with the enable and direction controls for an external bidirectional data buffer. Wait phases (Tw) lengthen the transfer while the target holds its ready input low.

An address register inside the block captures the full 20-bit address while the address strobe is high. It stands in for the external demultiplexing latch, so the bench and the neighbouring logic see a stable address for the rest of the transfer. Read data is taken from the shared lines as the transfer enters its last phase. It is returned together with a one-cycle completion pulse.

Top module: `bus_cycle_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls: `ale`=0, `rd_n`=1, `wr_n`=1, `den_n`=1, `dt_r`=0, `io_m`=0, `ad_oe`=0, `ad_o`=0, `a_hi`=0, `busy`=0, `done`=0, `lat_addr`=0 and `rdata`=0. `ad_o` is zero in every cycle in which `ad_oe` is low.
- R2: A request (`req_valid`=1) is accepted only at a clock edge when the sequencer is idle. A request held high while `busy`=1 starts no extra transfer and does not change the address, direction or data of the transfer in progress.
- R3: A transfer with no waits lasts four cycles: T1, T2, T3 and T4 in the four cycles after the accepting edge. `busy` is 1 in each of these cycles. `done` is 1 for exactly the one cycle after T4, and `busy` is 0 in that cycle.
- R4: `ale` is 1 only during T1. During T1, `ad_oe`=1 and `ad_o` carries address bits 7:0. `a_hi` carries address bits 19:8 from T1 through T4.
- R5: `lat_addr` takes the full 20-bit request address at the edge that ends T1. It holds that value until the T1 of the next transfer.
- R6: For a write (`req_write`=1): `dt_r`=1 from T1 to T4. `ad_oe`=1 and `ad_o` equals the write data from T2 to T4. `wr_n`=0 in T2, T3 and every Tw. `rd_n` stays 1.
- R7: For a read (`req_write`=0): `dt_r`=0 and `ad_oe`=0 after T1. `rd_n`=0 in T2, T3 and every Tw, and `wr_n` stays 1. `rdata` holds the value of `ad_i` sampled at the edge that starts T4, and it is valid while `done`=1.
- R8: `den_n` is 0 exactly in T2, T3 and the Tw phases, and 1 at all other times.
- R9: `io_m` is 1 for a port access (`req_io`=1) and 0 for a memory access, from T1 through T4. It is 0 when idle.
- R10: `ready` is sampled at the edge that ends T2. If it was 0 there, one Tw follows T3. The value of `ready` at the edge that ends T3 has no effect.
- R11: At the edge that ends each Tw, `ready`=0 gives another Tw and `ready`=1 moves to T4. With k wait phases the transfer lasts 4+k cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = port space, 0 = memory space |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Transfer in progress (T1..T4) |
| done | output | 1 | One-cycle pulse after T4 |
| rdata | output | 8 | Read result |
| ready | input | 1 | Target ready; 0 requests wait phases |
| ale | output | 1 | Address strobe, high in T1 |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Data buffer enable, active low |
| dt_r | output | 1 | Buffer direction, 1 = transmit |
| io_m | output | 1 | 1 = port access, 0 = memory access |
| ad_o | output | 8 | Shared address/data lines, driven value |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_i | input | 8 | Shared address/data lines, sensed value |
| a_hi | output | 12 | Address bits 19:8 |
| lat_addr | output | 20 | Address latched under `ale` |

## Verification
All pins are registered from the next phase. A request accepted at edge E0 therefore shows T1 pins in cycle 1, and with k waits shows T4 in cycle 4+k. `done` and `rdata` appear in cycle 5+k, and `lat_addr` first shows the new address in cycle 2. The bench samples every output at the falling edge of each numbered cycle and compares it with values computed from the cycle number, direction, space and wait count. It drives `ready` and `ad_i` for the edge that ends each cycle, so each sampling point and each capture edge is fixed by arithmetic.

// File: rtl/bcs_pkg.sv
`timescale 1ns/1ps
package bcs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5
  } phase_t;

  function automatic logic strobe_phase(phase_t p);
    return (p == PH_T2) || (p == PH_T3) || (p == PH_TW);
  endfunction
endpackage

// File: rtl/bcs_phase_fsm.sv
`timescale 1ns/1ps
module bcs_phase_fsm
  import bcs_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   req_valid,
  input  logic   ready,
  output phase_t ph_q,
  output phase_t ph_d,
  output logic   accept,
  output logic   done_q
);
  logic rdy_smp_q;

  always_comb begin
    ph_d   = ph_q;
    accept = 1'b0;
    case (ph_q)
      PH_IDLE: if (req_valid) begin
        ph_d   = PH_T1;
        accept = 1'b1;
      end
      PH_T1:   ph_d = PH_T2;
      PH_T2:   ph_d = PH_T3;
      PH_T3:   ph_d = rdy_smp_q ? PH_T4 : PH_TW;
      PH_TW:   ph_d = ready ? PH_T4 : PH_TW;
      PH_T4:   ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= PH_IDLE;
      rdy_smp_q <= 1'b1;
      done_q    <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      done_q <= (ph_q == PH_T4);
      if (ph_q == PH_T2) rdy_smp_q <= ready;
    end
  end

  a_r3_accept_to_t1: assert property (@(posedge clk) disable iff (rst)
    accept |=> (ph_q == PH_T1));
  a_r10_late_ready_waits: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_T2 && !ready) |=> ##1 (ph_q == PH_TW));
  a_r11_wait_extends: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_TW && !ready) |=> (ph_q == PH_TW));
  a_r3_done_after_t4: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_T4) |=> (done_q && ph_q == PH_IDLE));
  a_r2_busy_ignores_req: assert property (@(posedge clk) disable iff (rst)
    ((ph_q == PH_T1 || ph_q == PH_T2) && req_valid) |=> (ph_q != PH_T1));
endmodule

// File: rtl/bcs_pin_gen.sv
`timescale 1ns/1ps
module bcs_pin_gen
  import bcs_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 8,
  localparam int HW = AW - DW
) (
  input  logic          clk,
  input  logic          rst,
  input  phase_t        ph_q,
  input  phase_t        ph_d,
  input  logic          accept,
  input  logic          req_write,
  input  logic          req_io,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] ad_i,
  output logic          ale_q,
  output logic          rd_n_q,
  output logic          wr_n_q,
  output logic          den_n_q,
  output logic          dt_r_q,
  output logic          io_m_q,
  output logic          ad_oe_q,
  output logic [DW-1:0] ad_o_q,
  output logic [HW-1:0] a_hi_q,
  output logic [DW-1:0] rdata_q
);
  logic          wr_q, io_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  logic          wr_d, io_d, act, stb;
  logic [AW-1:0] addr_d;
  logic [DW-1:0] wdata_d;

  always_comb begin
    wr_d    = accept ? req_write : wr_q;
    io_d    = accept ? req_io    : io_q;
    addr_d  = accept ? req_addr  : addr_q;
    wdata_d = accept ? req_wdata : wdata_q;
    act     = (ph_d != PH_IDLE);
    stb     = strobe_phase(ph_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q    <= 1'b0;
      io_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      ale_q   <= 1'b0;
      rd_n_q  <= 1'b1;
      wr_n_q  <= 1'b1;
      den_n_q <= 1'b1;
      dt_r_q  <= 1'b0;
      io_m_q  <= 1'b0;
      ad_oe_q <= 1'b0;
      ad_o_q  <= '0;
      a_hi_q  <= '0;
      rdata_q <= '0;
    end else begin
      wr_q    <= wr_d;
      io_q    <= io_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      ale_q   <= (ph_d == PH_T1);
      rd_n_q  <= !(stb && !wr_d);
      wr_n_q  <= !(stb && wr_d);
      den_n_q <= !stb;
      dt_r_q  <= act && wr_d;
      io_m_q  <= act && io_d;
      ad_oe_q <= (ph_d == PH_T1) || (act && wr_d);
      if (ph_d == PH_T1)      ad_o_q <= addr_d[DW-1:0];
      else if (act && wr_d)   ad_o_q <= wdata_d;
      else                    ad_o_q <= '0;
      a_hi_q  <= act ? addr_d[AW-1:DW] : '0;
      if (ph_d == PH_T4 && ph_q != PH_T4 && !wr_q) rdata_q <= ad_i;
    end
  end

  a_r4_ale_excludes_strobes: assert property (@(posedge clk) disable iff (rst)
    ale_q |-> (rd_n_q && wr_n_q && den_n_q));
  a_r8_den_with_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !den_n_q |-> (!rd_n_q ^ !wr_n_q));
  a_r4_addr_hi_stable: assert property (@(posedge clk) disable iff (rst)
    (ph_q != PH_IDLE && $past(ph_q) != PH_IDLE) |-> $stable(a_hi_q));
  a_r7_read_floats: assert property (@(posedge clk) disable iff (rst)
    !rd_n_q |-> (!ad_oe_q && !dt_r_q));
  a_r1_undriven_zero: assert property (@(posedge clk) disable iff (rst)
    !ad_oe_q |-> (ad_o_q == '0));
endmodule

// File: rtl/bcs_addr_latch.sv
`timescale 1ns/1ps
module bcs_addr_latch #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ale,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);
  for (genvar b = 0; b < AW; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)      q[b] <= 1'b0;
      else if (ale) q[b] <= d[b];
    end
  end

  a_r5_capture_under_ale: assert property (@(posedge clk) disable iff (rst)
    ale |=> (q == $past(d)));
  a_r5_hold_without_ale: assert property (@(posedge clk) disable iff (rst)
    !ale |=> $stable(q));
endmodule

// File: rtl/bus_cycle_seq.sv
`timescale 1ns/1ps
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 8,
  localparam int HW = AW - DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_io,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  input  logic          ready,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          den_n,
  output logic          dt_r,
  output logic          io_m,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_i,
  output logic [HW-1:0] a_hi,
  output logic [AW-1:0] lat_addr
);
  phase_t ph_q, ph_d;
  logic   accept;

  bcs_phase_fsm u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .ready(ready),
    .ph_q(ph_q), .ph_d(ph_d), .accept(accept), .done_q(done)
  );

  bcs_pin_gen #(.AW(AW), .DW(DW)) u_pins (
    .clk(clk), .rst(rst), .ph_q(ph_q), .ph_d(ph_d), .accept(accept),
    .req_write(req_write), .req_io(req_io), .req_addr(req_addr),
    .req_wdata(req_wdata), .ad_i(ad_i),
    .ale_q(ale), .rd_n_q(rd_n), .wr_n_q(wr_n), .den_n_q(den_n),
    .dt_r_q(dt_r), .io_m_q(io_m), .ad_oe_q(ad_oe), .ad_o_q(ad_o),
    .a_hi_q(a_hi), .rdata_q(rdata)
  );

  bcs_addr_latch #(.AW(AW)) u_latch (
    .clk(clk), .rst(rst), .ale(ale), .d({a_hi, ad_o}), .q(lat_addr)
  );

  assign busy = (ph_q != PH_IDLE);

  a_r9_io_only_when_busy: assert property (@(posedge clk) disable iff (rst)
    io_m |-> busy);
  a_r3_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/test_bus_cycle_seq.sv
`timescale 1ns/1ps
module test_bus_cycle_seq;
  localparam int AW = 20;
  localparam int DW = 8;
  localparam int HW = AW - DW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic ready = 1'b1;
  logic [DW-1:0] ad_i = '0;
  logic busy, done, ale, rd_n, wr_n, den_n, dt_r, io_m, ad_oe;
  logic [DW-1:0] rdata, ad_o;
  logic [HW-1:0] a_hi;
  logic [AW-1:0] lat_addr;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  bus_cycle_seq i_bus_cycle_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata), .ready(ready),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .dt_r(dt_r),
    .io_m(io_m), .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i),
    .a_hi(a_hi), .lat_addr(lat_addr)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish (actual cycles=%0d expected < 100000)", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at t=%0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // One transfer; k wait phases; t3low drives ready low only at the edge ending T3;
  // hold keeps a conflicting request present while busy.
  task automatic run_xfer(logic w, logic io, logic [AW-1:0] addr,
                          logic [DW-1:0] wd, logic [DW-1:0] dev,
                          int k, logic t3low, logic hold);
    int last;
    logic stb;
    last = 4 + k;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_io = io;
    req_addr = addr; req_wdata = wd;
    ready = 1'b1; ad_i = ~dev;
    for (int i = 1; i <= last + 2; i++) begin
      @(negedge clk);
      if (i <= last) begin
        stb = (i >= 2) && (i <= 3 + k);
        check("R4 ale/a_hi", {19'd0, ale, a_hi}, {19'd0, (i == 1), addr[AW-1:DW]});
        check("R8 den_n", {31'd0, den_n}, {31'd0, !stb});
        check("R9 io_m", {31'd0, io_m}, {31'd0, io});
        check("R3 busy/done", {30'd0, busy, done}, {30'd0, 2'b10});
        if (i == 1)
          check("R4 T1 address drive", {23'd0, ad_oe, ad_o}, {23'd0, 1'b1, addr[DW-1:0]});
        else if (w)
          check("R6 write pins", {20'd0, rd_n, wr_n, dt_r, ad_oe, ad_o},
                {20'd0, 1'b1, !stb, 1'b1, 1'b1, wd});
        else
          check("R7 read pins", {20'd0, rd_n, wr_n, dt_r, ad_oe, ad_o},
                {20'd0, !stb, 1'b1, 1'b0, 1'b0, 8'd0});
        if (i == 4 && k > 0)
          check(k == 1 ? "R10 Tw after T3" : "R11 Tw after T3", {31'd0, den_n}, 32'd0);
        if (i == last)
          check(t3low ? "R10 ready at T3 end ignored" :
                (k > 1 ? "R11 length 4+k" : "R3 T4 strobes off"),
                {30'd0, rd_n, wr_n}, 32'd3);
        if (i >= 2)
          check("R5 latched address", {12'd0, lat_addr}, {12'd0, addr});
      end else if (i == last + 1) begin
        check("R3 done pulse", {30'd0, busy, done}, 32'd1);
        check("R1 idle pins", {23'd0, ale, rd_n, wr_n, den_n, dt_r, io_m, ad_oe, a_hi == 0, ad_o == 0},
              {23'd0, 9'b0_1_1_1_0_0_0_1_1});
        check("R5 latch holds", {12'd0, lat_addr}, {12'd0, addr});
        if (!w) check("R7 rdata", {24'd0, rdata}, {24'd0, dev});
      end else begin
        check(hold ? "R2 no restart while busy" : "R3 done one cycle",
              {29'd0, done, busy, ale}, 32'd0);
      end
      req_valid = hold && (i < last);
      if (hold) begin
        req_write = !w; req_io = !io; req_addr = ~addr; req_wdata = ~wd;
      end
      ready = !((k > 0 && i <= k + 2) || (t3low && i == 3));
      ad_i = (i >= 3 && i <= 3 + k) ? dev : ~dev;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset pins", {21'd0, busy, done, ale, rd_n, wr_n, den_n, dt_r, io_m, ad_oe, a_hi == 0, ad_o == 0},
          {21'd0, 11'b0_0_0_1_1_1_0_0_0_1_1});
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", {4'd0, rdata, lat_addr}, 32'd0);
    check("R1 idle busy", {30'd0, busy, done}, 32'd0);
    for (int n = 0; n < 32; n++) begin
      logic [AW-1:0] a;
      a = AW'((n * 32'h3A5C7 + 32'h01234));
      run_xfer(n[0], n[1], a, DW'(n * 37 + 5), DW'(n * 91 + 17),
               int'(n[3:2]), 1'b0, n[4]);
    end
    run_xfer(1'b1, 1'b0, 20'hFFFFF, 8'hFF, 8'h00, 0, 1'b0, 1'b0);
    run_xfer(1'b0, 1'b1, 20'h00000, 8'h00, 8'hFF, 5, 1'b0, 1'b0);
    run_xfer(1'b0, 1'b0, 20'h5A5A5, 8'h11, 8'hC3, 0, 1'b1, 1'b0);
    run_xfer(1'b1, 1'b1, 20'hA5A5A, 8'h3C, 8'h77, 0, 1'b1, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule